// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

The block takes interrupt events from on-chip sources and writes each one into a circular ring in memory as a 128-bit vector. The vector goes out as four 32-bit memory writes. The block keeps a byte-offset write pointer. The host keeps a read pointer and updates it through the register port. The ring counts as empty when the two pointers match. When a new vector would make the write pointer catch up with the read pointer, the block can flag an overflow. That flag rides in bit 0 of the write pointer the block reports, and it stays set until software clears it.

After each vector, the block can also copy the write pointer, flag included, to a 40-bit memory location, so the host can poll memory instead of a register. It pulses an interrupt line when the ring turns from empty to non-empty. A busy output covers the time when memory writes are still outstanding.

Software programs the block through a small write-only register port:

| Offset | Register | Contents |
|--------|----------|----------|
| 0 | control | bit 0 ring enable; bits [5:1] base-2 log of the ring size in 32-bit words; bit 6 overflow-detect enable; bit 7 overflow clear (write 1); bit 8 pointer writeback enable |
| 1 | interrupt enable | bit 0 |
| 2 | ring base | in 256-byte units |
| 3 | read pointer | bytes |
| 4 | write pointer load | bytes |
| 5 | writeback address, low | address bits [31:0] |
| 6 | writeback address, high | address bits [39:32], taken from bits [7:0] of the written value |

The memory side is a 32-bit write-request port with address, data and a valid/ready handshake.

Top module: `irq_ring_writer`

## Requirements
- R1: An accepted event produces four memory writes in ascending order, to addresses base*256 + wptr + 0, 4, 8 and 12. Word 0 is {24'b0, src}, word 1 is {4'b0, data[27:0]}, word 2 is {pasid, vmid, ring_id}, and word 3 is zero.
- R2: Pointers are byte offsets with bits [3:1] always zero. After the fourth word is accepted, the write pointer advances by 16 and wraps at 4 << size bytes, where size is control bits [5:1].
- R3: The overflow flag sets when overflow detection (control bit 6) is enabled and the advanced write pointer equals the read pointer. The flag appears as bit 0 of wptr_o and of the writeback value. With detection disabled, the same condition sets nothing.
- R4: Once set, the overflow flag stays set across later vectors. It clears on the edge that writes the control register with bit 7 set.
- R5: With writeback enabled (control bit 8), a fifth write follows each vector. It goes to the 40-bit writeback address and carries {write pointer | overflow flag}. With writeback disabled, no fifth write is made.
- R6: evt_ready is low while a vector or writeback is in flight, while the ring is disabled (control bit 0), or while the interrupt is disabled (register 1 bit 0). An event offered then causes no memory write.
- R7: irq_o is a single-cycle pulse, raised after a vector whose write began with the write pointer equal to the read pointer.
- R8: busy_o is high from the cycle after an event is accepted until the last memory write of that event is accepted.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold their values.
- R10: After reset, wptr_o, irq_o, busy_o, mem_valid and evt_ready are zero. A register write to offset 4 loads the write pointer, and a write to offset 3 sets the read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken |
| evt_src | input | 8 | Source id |
| evt_data | input | 28 | Source data |
| evt_ring | input | 8 | Ring id |
| evt_vmid | input | 8 | Virtual machine id |
| evt_pasid | input | 16 | Process address space id |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 40 | Byte address of the write |
| mem_data | output | 32 | Write data |
| wptr_o | output | 32 | Write pointer with overflow flag in bit 0 |
| irq_o | output | 1 | Empty-to-non-empty interrupt pulse |
| busy_o | output | 1 | Memory writes outstanding |

## Verification
The bench keeps the default 40-bit address and 18-bit pointer widths and programs a ring size of 16 words, so the ring holds only four entries. That makes wraparound and overflow reachable within a handful of events. It lets the bench watch the overflow flag persist across a further vector and then clear. A memory model that stalls two cycles out of three exercises the request-hold rule in the middle of a vector and during writeback.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_INTR  = 3'd1;
  localparam logic [2:0] OFS_BASE  = 3'd2;
  localparam logic [2:0] OFS_RPTR  = 3'd3;
  localparam logic [2:0] OFS_WPTR  = 3'd4;
  localparam logic [2:0] OFS_WB_LO = 3'd5;
  localparam logic [2:0] OFS_WB_HI = 3'd6;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SZ_LSB   = 1;
  localparam int CTRL_DET_BIT  = 6;
  localparam int CTRL_CLR_BIT  = 7;
  localparam int CTRL_WB_BIT   = 8;

  localparam int ENTRY_BYTES = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_WB   = 2'd2
  } wr_state_t;

  typedef logic [3:0][31:0] vec_words_t;

  function automatic vec_words_t pack_vec(
    input logic [7:0]  src,
    input logic [27:0] data,
    input logic [7:0]  ring,
    input logic [7:0]  vmid,
    input logic [15:0] pasid
  );
    vec_words_t w;
    w[0] = {24'd0, src};
    w[1] = {4'd0, data};
    w[2] = {pasid, vmid, ring};
    w[3] = 32'd0;
    return w;
  endfunction

endpackage

// File: rtl/irq_ring_regs.sv
module irq_ring_regs
  import irq_ring_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PTR_W  = 18,
  parameter int LOG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              ring_en,
  output logic              intr_en,
  output logic [LOG_W-1:0]  size_log,
  output logic              det_en,
  output logic              wb_en,
  output logic              ovf_clr,
  output logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  rptr,
  output logic              sw_wptr_we,
  output logic [PTR_W-1:0]  sw_wptr_val
);
  localparam int BASE_W = ADDR_W - 8;
  localparam int HI_W   = ADDR_W - 32;

  logic [BASE_W-1:0] base_q;
  logic [31:0]       wb_lo_q;
  logic [HI_W-1:0]   wb_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en  <= 1'b0;
      intr_en  <= 1'b0;
      size_log <= '0;
      det_en   <= 1'b0;
      wb_en    <= 1'b0;
      base_q   <= '0;
      wb_lo_q  <= '0;
      wb_hi_q  <= '0;
      rptr     <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_CTRL: begin
          ring_en  <= reg_wdata[CTRL_EN_BIT];
          size_log <= reg_wdata[CTRL_SZ_LSB +: LOG_W];
          det_en   <= reg_wdata[CTRL_DET_BIT];
          wb_en    <= reg_wdata[CTRL_WB_BIT];
        end
        OFS_INTR:  intr_en <= reg_wdata[0];
        OFS_BASE:  base_q  <= BASE_W'(reg_wdata);
        OFS_RPTR:  rptr    <= {reg_wdata[PTR_W-1:4], 4'h0};
        OFS_WB_LO: wb_lo_q <= reg_wdata;
        OFS_WB_HI: wb_hi_q <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ovf_clr     = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];
    sw_wptr_we  = reg_we && (reg_addr == OFS_WPTR);
    sw_wptr_val = {reg_wdata[PTR_W-1:4], 4'h0};
    ring_base   = {base_q, 8'h00};
    wb_addr     = {wb_hi_q, wb_lo_q};
  end

endmodule

// File: rtl/irq_ring_ptr.sv
module irq_ring_ptr
  import irq_ring_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int LOG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [LOG_W-1:0] size_log,
  input  logic [PTR_W-1:0] rptr,
  input  logic             det_en,
  input  logic             clr,
  input  logic             sw_we,
  input  logic [PTR_W-1:0] sw_val,
  output logic [PTR_W-1:0] wptr_q,
  output logic             ovf_q,
  output logic [PTR_W-1:0] wptr_nxt,
  output logic             ovf_nxt,
  output logic             was_idle
);
  localparam int MAX_LOG = PTR_W - 2;

  logic [LOG_W-1:0] eff_log;
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] rptr_m;
  logic             hit;

  always_comb begin
    eff_log  = (size_log > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : size_log;
    mask     = ~({PTR_W{1'b1}} << (eff_log + LOG_W'(2)));
    rptr_m   = rptr & mask;
    wptr_nxt = (wptr_q + PTR_W'(ENTRY_BYTES)) & mask;
    hit      = det_en && (wptr_nxt == rptr_m);
    ovf_nxt  = hit || (ovf_q && !clr);
    was_idle = (wptr_q == rptr_m);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (adv) begin
        wptr_q <= wptr_nxt;
      end else if (sw_we) begin
        wptr_q <= sw_val;
      end
      ovf_q <= (adv && hit) || (ovf_q && !clr);
    end
  end

endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irq_ring_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PTR_W  = 18,
  parameter int LOG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [7:0]        evt_src,
  input  logic [27:0]       evt_data,
  input  logic [7:0]        evt_ring,
  input  logic [7:0]        evt_vmid,
  input  logic [15:0]       evt_pasid,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic [31:0]       wptr_o,
  output logic              irq_o,
  output logic              busy_o
);
  logic              ring_en, intr_en, det_en, wb_en, ovf_clr;
  logic [LOG_W-1:0]  size_log;
  logic [ADDR_W-1:0] ring_base, wb_addr;
  logic [PTR_W-1:0]  rptr, sw_wptr_val;
  logic              sw_wptr_we;
  logic [PTR_W-1:0]  wptr_q, wptr_nxt;
  logic              ovf_q, ovf_nxt, was_idle;

  wr_state_t  st;
  logic [1:0] beat;
  vec_words_t vec_q, vec_d;
  logic       accept, adv, beat_done;

  irq_ring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LOG_W(LOG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ring_en(ring_en), .intr_en(intr_en), .size_log(size_log), .det_en(det_en),
    .wb_en(wb_en), .ovf_clr(ovf_clr), .ring_base(ring_base), .wb_addr(wb_addr),
    .rptr(rptr), .sw_wptr_we(sw_wptr_we), .sw_wptr_val(sw_wptr_val)
  );

  irq_ring_ptr #(.PTR_W(PTR_W), .LOG_W(LOG_W)) u_ptr (
    .clk(clk), .rst(rst), .adv(adv), .size_log(size_log), .rptr(rptr),
    .det_en(det_en), .clr(ovf_clr), .sw_we(sw_wptr_we), .sw_val(sw_wptr_val),
    .wptr_q(wptr_q), .ovf_q(ovf_q), .wptr_nxt(wptr_nxt), .ovf_nxt(ovf_nxt),
    .was_idle(was_idle)
  );

  always_comb begin
    evt_ready = (st == ST_IDLE) && ring_en && intr_en;
    accept    = evt_valid && evt_ready;
    vec_d     = pack_vec(evt_src, evt_data, evt_ring, evt_vmid, evt_pasid);
    beat_done = mem_valid && mem_ready;
    adv       = (st == ST_VEC) && beat_done && (beat == 2'd3);
    busy_o    = (st != ST_IDLE);
    wptr_o    = 32'(wptr_q) | 32'(ovf_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      beat      <= 2'd0;
      vec_q     <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            vec_q     <= vec_d;
            beat      <= 2'd0;
            st        <= ST_VEC;
            mem_valid <= 1'b1;
            mem_addr  <= ring_base + ADDR_W'(wptr_q);
            mem_data  <= vec_d[0];
          end
        end
        ST_VEC: begin
          if (beat_done) begin
            if (beat == 2'd3) begin
              irq_o <= was_idle;
              if (wb_en) begin
                st        <= ST_WB;
                mem_addr  <= wb_addr;
                mem_data  <= 32'(wptr_nxt) | 32'(ovf_nxt);
              end else begin
                st        <= ST_IDLE;
                mem_valid <= 1'b0;
              end
            end else begin
              beat     <= beat + 2'd1;
              mem_addr <= mem_addr + ADDR_W'(4);
              mem_data <= vec_q[beat + 2'd1];
            end
          end
        end
        ST_WB: begin
          if (beat_done) begin
            st        <= ST_IDLE;
            mem_valid <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_ring_writer_chk.sv
module irq_ring_writer_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [31:0]       wptr_o,
  input logic              irq_o,
  input logic              busy_o
);

  p_evt_gate_r6: assert property (@(posedge clk) disable iff (rst)
    evt_ready |-> !busy_o);

  p_take_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_ready) |=> (busy_o && mem_valid));

  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_ptr_align_r2: assert property (@(posedge clk) disable iff (rst)
    wptr_o[3:1] == 3'b000);

  p_ovf_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wptr_o[0]) |-> $past(mem_valid && mem_ready));

endmodule

bind irq_ring_writer irq_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .wptr_o(wptr_o), .irq_o(irq_o), .busy_o(busy_o)
);

// File: tb/sim_irq_ring_writer.sv
`timescale 1ns/1ps
module sim_irq_ring_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [7:0]  evt_src = '0;
  logic [27:0] evt_data = '0;
  logic [7:0]  evt_ring = '0;
  logic [7:0]  evt_vmid = '0;
  logic [15:0] evt_pasid = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic [31:0] wptr_o;
  logic        irq_o;
  logic        busy_o;

  localparam logic [39:0] RING_BASE = 40'h00_0001_0000;
  localparam logic [39:0] WB_ADDR   = 40'h12_0000_0040;
  localparam logic [31:0] CTRL_RUN  = 32'h149;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int wb_cnt = 0;
  int wr_cnt = 0;
  int stall_bad = 0;
  int stall_cnt = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [31:0] wb_val = '0;
  logic [31:0] ring_mem [0:15];
  bit          prev_pend = 1'b0;
  logic [39:0] prev_addr = '0;
  logic [31:0] prev_data = '0;

  irq_ring_writer u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src), .evt_data(evt_data),
    .evt_ring(evt_ring), .evt_vmid(evt_vmid), .evt_pasid(evt_pasid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .wptr_o(wptr_o), .irq_o(irq_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    mem_ready <= stall_mode ? ((stall_cnt % 3) == 2) : 1'b1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (irq_o) irq_cnt = irq_cnt + 1;
      if (prev_pend && (!mem_valid || mem_addr != prev_addr || mem_data != prev_data))
        stall_bad = stall_bad + 1;
      prev_pend = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_data = mem_data;
      if (mem_valid && mem_ready) begin
        wr_cnt = wr_cnt + 1;
        if (mem_addr == WB_ADDR) begin
          wb_val = mem_data;
          wb_cnt = wb_cnt + 1;
        end else if (mem_addr >= RING_BASE && mem_addr < RING_BASE + 40'd64) begin
          ring_mem[4'((mem_addr - RING_BASE) >> 2)] = mem_data;
        end
      end
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp=<50000", cyc);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_evt(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                          input logic [7:0] v, input logic [15:0] p);
    @(negedge clk);
    evt_valid = 1'b1; evt_src = s; evt_data = d; evt_ring = r; evt_vmid = v; evt_pasid = p;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after accept", 64'(busy_o), 64'd1);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_vec(input int idx, input logic [7:0] s, input logic [27:0] d,
                         input logic [7:0] r, input logic [7:0] v, input logic [15:0] p);
    logic [31:0] e0, e1, e2;
    e0 = {24'd0, s};
    e1 = {4'd0, d};
    e2 = {p, v, r};
    chk(ring_mem[idx]   == e0, "R1 word0", 64'(ring_mem[idx]), 64'(e0));
    chk(ring_mem[idx+1] == e1, "R1 word1", 64'(ring_mem[idx+1]), 64'(e1));
    chk(ring_mem[idx+2] == e2, "R1 word2", 64'(ring_mem[idx+2]), 64'(e2));
    chk(ring_mem[idx+3] == 32'd0, "R1 word3", 64'(ring_mem[idx+3]), 64'd0);
  endtask

  task automatic t_reset();
    chk(wptr_o == 32'd0, "R10 reset wptr", 64'(wptr_o), 64'd0);
    chk(!busy_o && !irq_o && !mem_valid, "R10 reset outputs",
        64'({busy_o, irq_o, mem_valid}), 64'd0);
    chk(!evt_ready, "R10 reset ready", 64'(evt_ready), 64'd0);
  endtask

  task automatic t_config();
    reg_wr(3'd2, 32'h0000_0100);
    reg_wr(3'd5, 32'h0000_0040);
    reg_wr(3'd6, 32'h0000_0012);
    reg_wr(3'd3, 32'd0);
    reg_wr(3'd0, CTRL_RUN);
    chk(!evt_ready, "R6 intr off blocks", 64'(evt_ready), 64'd0);
    reg_wr(3'd1, 32'd1);
    chk(evt_ready, "R6 ready when enabled", 64'(evt_ready), 64'd1);
  endtask

  task automatic t_first();
    int irq0 = irq_cnt;
    send_evt(8'hA5, 28'hABC_DEF1, 8'h13, 8'h07, 16'hBEEF);
    chk_vec(0, 8'hA5, 28'hABC_DEF1, 8'h13, 8'h07, 16'hBEEF);
    chk(wptr_o == 32'd16, "R2 advance 16", 64'(wptr_o), 64'd16);
    chk(wb_cnt == 1 && wb_val == 32'd16, "R5 writeback value", 64'(wb_val), 64'd16);
    chk(irq_cnt == irq0 + 1, "R7 irq on empty ring", 64'(irq_cnt - irq0), 64'd1);
  endtask

  task automatic t_second();
    int irq0 = irq_cnt;
    send_evt(8'h01, 28'h000_0002, 8'hFF, 8'h80, 16'h0001);
    chk_vec(4, 8'h01, 28'h000_0002, 8'hFF, 8'h80, 16'h0001);
    chk(wptr_o == 32'd32, "R2 second advance", 64'(wptr_o), 64'd32);
    chk(irq_cnt == irq0, "R7 no irq when non-empty", 64'(irq_cnt - irq0), 64'd0);
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    send_evt(8'h3C, 28'hFFF_FFFF, 8'h00, 8'h55, 16'h1234);
    stall_mode = 1'b0;
    chk_vec(8, 8'h3C, 28'hFFF_FFFF, 8'h00, 8'h55, 16'h1234);
    chk(stall_bad == 0, "R9 request held under stall", 64'(stall_bad), 64'd0);
    chk(wb_val == 32'd48, "R5 writeback after stall", 64'(wb_val), 64'd48);
  endtask

  task automatic t_overflow();
    send_evt(8'h44, 28'h123_4567, 8'h21, 8'h02, 16'hCAFE);
    chk_vec(12, 8'h44, 28'h123_4567, 8'h21, 8'h02, 16'hCAFE);
    chk(wptr_o == 32'd1, "R3 wrap to 0 with flag", 64'(wptr_o), 64'd1);
    chk(wb_val == 32'd1, "R3 flag in writeback", 64'(wb_val), 64'd1);
  endtask

  task automatic t_hold_clear();
    send_evt(8'h77, 28'h000_0077, 8'h01, 8'h01, 16'h0077);
    chk_vec(0, 8'h77, 28'h000_0077, 8'h01, 8'h01, 16'h0077);
    chk(wptr_o == 32'd17, "R4 flag held", 64'(wptr_o), 64'd17);
    reg_wr(3'd0, CTRL_RUN | 32'h80);
    chk(wptr_o == 32'd16, "R4 flag cleared", 64'(wptr_o), 64'd16);
  endtask

  task automatic t_no_detect();
    reg_wr(3'd0, 32'h109);
    reg_wr(3'd3, 32'd32);
    send_evt(8'h09, 28'h000_0009, 8'h09, 8'h09, 16'h0009);
    chk(wptr_o == 32'd32, "R3 no flag when detect off", 64'(wptr_o), 64'd32);
    chk(wb_val == 32'd32, "R5 writeback no flag", 64'(wb_val), 64'd32);
  endtask

  task automatic t_no_wb();
    int wb0 = wb_cnt;
    reg_wr(3'd0, 32'h009);
    send_evt(8'h0A, 28'h000_000A, 8'h0A, 8'h0A, 16'h000A);
    chk(wb_cnt == wb0, "R5 no writeback when off", 64'(wb_cnt - wb0), 64'd0);
    chk(wptr_o == 32'd48, "R2 pointer without writeback", 64'(wptr_o), 64'd48);
  endtask

  task automatic t_blocked();
    int w0;
    reg_wr(3'd1, 32'd0);
    w0 = wr_cnt;
    @(negedge clk);
    evt_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk(!evt_ready, "R6 intr disabled", 64'(evt_ready), 64'd0);
    evt_valid = 1'b0;
    chk(wr_cnt == w0 && wptr_o == 32'd48, "R6 no write while intr off",
        64'(wr_cnt - w0), 64'd0);
    reg_wr(3'd1, 32'd1);
    reg_wr(3'd0, 32'h008);
    @(negedge clk);
    evt_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk(!evt_ready, "R6 ring disabled", 64'(evt_ready), 64'd0);
    evt_valid = 1'b0;
    chk(wr_cnt == w0, "R6 no write while ring off", 64'(wr_cnt - w0), 64'd0);
    reg_wr(3'd4, 32'd0);
    reg_wr(3'd3, 32'd0);
    chk(wptr_o == 32'd0, "R10 pointer load", 64'(wptr_o), 64'd0);
    reg_wr(3'd4, 32'd32);
    chk(wptr_o == 32'd32, "R10 pointer load nonzero", 64'(wptr_o), 64'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_first();
    t_second();
    t_stall();
    t_overflow();
    t_hold_clear();
    t_no_detect();
    t_no_wb();
    t_blocked();
    done = 1'b1;
    finish_up();
  end

endmodule